// File: doc/BRIEF.md
# Prescaled Channel Timebase Counter

This block is the counting core of one timer channel. A 16-bit up-counter advances on count events. Each count event is either a strobe from an internal divider, which gives the system clock divided by 1, 2, 4 or 8, or an edge seen on one of four external clock pins. External pins are synchronised into the system clock domain, and the active edge is selectable. A run bit gates all counting. While the run bit is low, the count is frozen and the divider phase restarts.

A clear-mode field lets the counter run freely, or return to zero after a match/capture event from general register A or from general register B. Those events come in as strobes from compare/capture units outside the block. The clear is not immediate: it takes effect at the next count event, so a period value P gives a cycle of P+1 counts. A wrap from 0xFFFF to 0x0000 sets an overflow flag. That flag drives an interrupt request through an enable input, and a clear strobe resets it.

Top module: `tcnt_timebase`

## Requirements
- R1: While `rst` is high and in the cycle after it, `count_o` is 0 and `ovf_flag_o` and `ovf_irq_o` are 0.
- R2: While `run_i` is 0, `count_o` holds its value, no overflow is flagged, and the divider phase returns to zero. Clear events arriving while stopped are not remembered.
- R3: `src_sel_i` 000, 001, 010 and 011 select the system clock divided by 1, 2, 4 and 8. After M consecutive clock edges with `run_i` high, counted from a stopped state, the count is floor(M/d).
- R4: `src_sel_i` 100 to 111 select `ext_clk_i[0]` to `ext_clk_i[3]`. Pins that are not selected do not change the count.
- R5: For external sources, `edge_sel_i` 00 counts rising edges and 01 counts falling edges, so one full pin period adds 1. The values 10 and 11 count both edges, so one full pin period adds 2.
- R6: With `clr_mode_i` 01, an `evt_a_i` pulse makes the next count event load 0 instead of incrementing. A compare event at count P therefore gives a period of P+1 count events. `evt_b_i` is ignored in this mode.
- R7: With `clr_mode_i` 10, the same clearing behaviour applies to `evt_b_i`, and `evt_a_i` is ignored.
- R8: With `clr_mode_i` 00 or 11, both event inputs are ignored and the counter wraps from 0xFFFF to 0x0000.
- R9: A wrap from 0xFFFF to 0x0000 sets `ovf_flag_o`. `ovf_irq_o` equals `ovf_flag_o` AND `ovf_ie_i`.
- R10: `ovf_clr_i` high at a clock edge clears the flag. If a wrap happens at the same edge, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Count enable |
| src_sel_i | input | 3 | Count source select |
| edge_sel_i | input | 2 | Active edge for external sources |
| clr_mode_i | input | 2 | Clear mode |
| ext_clk_i | input | 4 | External clock pins (asynchronous) |
| evt_a_i | input | 1 | Match/capture event from register A |
| evt_b_i | input | 1 | Match/capture event from register B |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ovf_clr_i | input | 1 | Overflow flag clear (flag write of 0) |
| count_o | output | 16 | Counter value |
| tick_o | output | 1 | Count event in this cycle |
| ovf_flag_o | output | 1 | Overflow flag |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
Two pairs of actions can land on the same clock edge.

The first pair is a wrap of the counter and a software clear of the overflow flag. To provoke it, the bench runs the counter from the system clock up to 0xFFFF. It then holds `ovf_clr_i` high across the edge that wraps. The flag is expected to be 1 after that edge and 0 after the next edge, when the clear is still held.

The second pair is a clear event and a count event. The bench generates the compare strobe from the visible count, using both an undivided and a divided source. It then checks that the count after M edges equals the arithmetic sequence with period P+1.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    localparam int CNT_W   = 16;
    localparam int N_EXT   = 4;
    localparam int N_DIV   = 4;   // divide by 1, 2, 4, 8
    localparam int DIV_W   = N_DIV - 1;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_BTH2 = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_SYNC = 2'b11   // treated as free-running
    } clr_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic pick_edge(edge_mode_e m, edge_ev_t e);
        case (m)
            EDGE_RISE: return e.rise;
            EDGE_FALL: return e.fall;
            default:   return e.rise | e.fall;
        endcase
    endfunction

endpackage

// File: rtl/tcnt_prescaler.sv
module tcnt_prescaler
    import tcnt_pkg::*;
#(
    parameter int NDIV = N_DIV
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_i,
    output logic [NDIV-1:0] strb_o
);
    localparam int PW = (NDIV > 1) ? NDIV - 1 : 1;

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) phase_q <= '0;
        else               phase_q <= phase_q + 1'b1;
    end

    assign strb_o[0] = 1'b1;
    for (genvar k = 1; k < NDIV; k++) begin : g_div
        assign strb_o[k] = &phase_q[k-1:0];
    end

    for (genvar k = 2; k < NDIV; k++) begin : g_chk
        assert_div_nest_R3: assert property (@(posedge clk) disable iff (rst)
            strb_o[k] |-> strb_o[k-1]);
    end

endmodule

// File: rtl/tcnt_ext_edge.sv
module tcnt_ext_edge
    import tcnt_pkg::*;
#(
    parameter int NPIN = N_EXT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPIN-1:0]     pin_i,
    output edge_ev_t [NPIN-1:0] ev_o
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= pin_i[i];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign ev_o[i].rise = s2_q & ~s3_q;
        assign ev_o[i].fall = ~s2_q & s3_q;

        assert_edge_excl_R5: assert property (@(posedge clk) disable iff (rst)
            !(ev_o[i].rise && ev_o[i].fall));
    end

endmodule

// File: rtl/tcnt_core.sv
module tcnt_core
    import tcnt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         tick_i,
    input  clr_mode_e    mode_i,
    input  logic         evt_a_i,
    input  logic         evt_b_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] cnt_o,
    output logic         flag_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;
    logic         pend_q;
    logic         flag_q;
    logic         clr_evt;
    logic         do_clear;
    logic         wrap;

    always_comb begin
        case (mode_i)
            CLR_ON_A: clr_evt = run_i & evt_a_i;
            CLR_ON_B: clr_evt = run_i & evt_b_i;
            default:  clr_evt = 1'b0;
        endcase
    end

    assign do_clear = tick_i & (pend_q | clr_evt);
    assign wrap     = tick_i & ~(pend_q | clr_evt) & (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (tick_i)       pend_q <= 1'b0;
            else if (clr_evt) pend_q <= 1'b1;

            if (do_clear)    cnt_q <= '0;
            else if (tick_i) cnt_q <= cnt_q + 1'b1;

            if (wrap)            flag_q <= 1'b1;
            else if (flag_clr_i) flag_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> $stable(cnt_q));
    assert_step_legal_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
    assert_clear_next_R6: assert property (@(posedge clk) disable iff (rst)
        (tick_i && pend_q) |=> cnt_q == '0);
    assert_flag_src_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(cnt_q) == TOP);

endmodule

// File: rtl/tcnt_timebase.sv
module tcnt_timebase
    import tcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [2:0]       src_sel_i,
    input  logic [1:0]       edge_sel_i,
    input  logic [1:0]       clr_mode_i,
    input  logic [N_EXT-1:0] ext_clk_i,
    input  logic             evt_a_i,
    input  logic             evt_b_i,
    input  logic             ovf_ie_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             tick_o,
    output logic             ovf_flag_o,
    output logic             ovf_irq_o
);
    logic [N_DIV-1:0]       div_strb;
    edge_ev_t [N_EXT-1:0]   ext_ev;
    logic                   src_tick;

    tcnt_prescaler #(.NDIV(N_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run_i),
        .strb_o (div_strb)
    );

    tcnt_ext_edge #(.NPIN(N_EXT)) u_ext (
        .clk   (clk),
        .rst   (rst),
        .pin_i (ext_clk_i),
        .ev_o  (ext_ev)
    );

    always_comb begin
        if (src_sel_i[2]) src_tick = pick_edge(edge_mode_e'(edge_sel_i), ext_ev[src_sel_i[1:0]]);
        else              src_tick = div_strb[src_sel_i[1:0]];
    end

    assign tick_o = run_i & src_tick;

    tcnt_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run_i),
        .tick_i     (tick_o),
        .mode_i     (clr_mode_e'(clr_mode_i)),
        .evt_a_i    (evt_a_i),
        .evt_b_i    (evt_b_i),
        .flag_clr_i (ovf_clr_i),
        .cnt_o      (count_o),
        .flag_o     (ovf_flag_o)
    );

    assign ovf_irq_o = ovf_flag_o & ovf_ie_i;

    assert_no_tick_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> !tick_o);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (tick_o && count_o == '1 && clr_mode_i[0] == clr_mode_i[1]) |=> ovf_flag_o);

endmodule

// File: tb/tcnt_timebase_bench.sv
module tcnt_timebase_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 1'b0;
    logic [2:0]  src_sel_i = '0;
    logic [1:0]  edge_sel_i = '0;
    logic [1:0]  clr_mode_i = '0;
    logic [3:0]  ext_clk_i = '0;
    logic        evt_a_i, evt_b_i;
    logic        ovf_ie_i = 1'b0;
    logic        ovf_clr_i = 1'b0;
    logic [15:0] count_o;
    logic        tick_o, ovf_flag_o, ovf_irq_o;

    logic        en_a = 1'b0, en_b = 1'b0, force_a = 1'b0, force_b = 1'b0;
    logic [15:0] per_a = '0, per_b = '0;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign evt_a_i = force_a | (en_a && count_o == per_a);
    assign evt_b_i = force_b | (en_b && count_o == per_b);

    tcnt_timebase u_tcnt_timebase (
        .clk(clk), .rst(rst), .run_i(run_i), .src_sel_i(src_sel_i),
        .edge_sel_i(edge_sel_i), .clr_mode_i(clr_mode_i), .ext_clk_i(ext_clk_i),
        .evt_a_i(evt_a_i), .evt_b_i(evt_b_i), .ovf_ie_i(ovf_ie_i),
        .ovf_clr_i(ovf_clr_i), .count_o(count_o), .tick_o(tick_o),
        .ovf_flag_o(ovf_flag_o), .ovf_irq_o(ovf_irq_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic restart();
        run_i = 1'b0; en_a = 0; en_b = 0; force_a = 0; force_b = 0;
        ext_clk_i = '0; ovf_clr_i = 0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic pulses(input int idx, input int k, input int half);
        for (int p = 0; p < k; p++) begin
            ext_clk_i[idx] = 1'b1; step(half);
            ext_clk_i[idx] = 1'b0; step(half);
        end
        step(6);
    endtask

    initial begin
        // R1 reset state
        step(3);
        chk("R1 count", count_o, 0);
        chk("R1 flag", ovf_flag_o, 0);
        chk("R1 irq", ovf_irq_o, 0);

        // R3 internal sources, several run lengths
        for (int s = 0; s < 4; s++) begin
            for (int m = 1; m <= 37; m += 9) begin
                restart();
                src_sel_i = 3'(s); clr_mode_i = 2'b00;
                run_i = 1'b1; step(m);
                chk($sformatf("R3 src=%0d m=%0d", s, m), count_o, m >> s);
            end
        end

        // R2 stop holds value and restarts divider phase
        restart();
        src_sel_i = 3'd3; run_i = 1'b1; step(13);   // count 1, phase 5
        run_i = 1'b0; step(20);
        chk("R2 hold", count_o, 1);
        run_i = 1'b1; step(7);
        chk("R2 phase restart", count_o, 1);
        step(1);
        chk("R2 resume", count_o, 2);
        // event while stopped not remembered
        run_i = 1'b0; clr_mode_i = 2'b01; force_a = 1; step(1); force_a = 0;
        src_sel_i = 3'd0; run_i = 1'b1; step(1);
        chk("R2 stopped event ignored", count_o, 3);

        // R4/R5 external sources and edge modes
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 4; e++) begin
                restart();
                src_sel_i = 3'(4 + p); edge_sel_i = 2'(e); clr_mode_i = 2'b00;
                run_i = 1'b1;
                pulses((p + 1) % 4, 3, 4);
                chk($sformatf("R4 unselected pin p=%0d", p), count_o, 0);
                pulses(p, 5, 3 + e);
                chk($sformatf("R5 pin=%0d edge=%0d", p, e), count_o, (e >= 2) ? 10 : 5);
            end
        end

        // R6 clear on A, undivided and divided
        for (int d = 0; d < 2; d++) begin
            for (int pv = 2; pv <= 6; pv += 4) begin
                restart();
                src_sel_i = 3'(d); clr_mode_i = 2'b01;
                en_a = 1; per_a = 16'(pv);
                en_b = 1; per_b = 16'(1);
                run_i = 1'b1;
                for (int m = 1; m <= 30; m++) begin
                    step(1);
                    chk($sformatf("R6 d=%0d P=%0d m=%0d", d, pv, m), count_o, (m >> d) % (pv + 1));
                end
            end
        end

        // R7 clear on B, A ignored
        restart();
        src_sel_i = 3'd0; clr_mode_i = 2'b10;
        en_b = 1; per_b = 16'd4; en_a = 1; per_a = 16'd2;
        run_i = 1'b1;
        for (int m = 1; m <= 20; m++) begin
            step(1);
            chk($sformatf("R7 m=%0d", m), count_o, m % 5);
        end

        // R8 modes 00 and 11 ignore events
        for (int md = 0; md < 4; md += 3) begin
            restart();
            src_sel_i = 3'd0; clr_mode_i = 2'(md);
            en_a = 1; per_a = 16'd3; en_b = 1; per_b = 16'd5;
            run_i = 1'b1; step(12);
            chk($sformatf("R8 mode=%0d", md), count_o, 12);
        end

        // R8/R9/R10 wrap, flag, irq, clear collision
        restart();
        src_sel_i = 3'd0; clr_mode_i = 2'b00; ovf_ie_i = 1'b0;
        run_i = 1'b1; step(65535);
        chk("R8 at top", count_o, 65535);
        chk("R9 flag before wrap", ovf_flag_o, 0);
        ovf_clr_i = 1'b1; step(1);
        chk("R8 wrapped", count_o, 0);
        chk("R10 set wins", ovf_flag_o, 1);
        chk("R9 irq masked", ovf_irq_o, 0);
        ovf_clr_i = 1'b0; ovf_ie_i = 1'b1; #1;
        chk("R9 irq enabled", ovf_irq_o, 1);
        run_i = 1'b0; ovf_clr_i = 1'b1; step(1);
        ovf_clr_i = 1'b0;
        chk("R10 clear", ovf_flag_o, 0);
        chk("R9 irq after clear", ovf_irq_o, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                checks++; errs++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule